// File: doc/BRIEF.md
# Protected Page Write Commit Engine

This block sits behind the protocol front end of a serial byte-wide memory slave and owns the non-volatile write path. The front end decodes the bus and hands over three kinds of event: a word address, a stream of data bytes, and either a stop (commit) or a repeated start (abandon). Data bytes are collected in a page buffer of eight slots. The write pointer steps through the slots and wraps inside the current eight-byte row. Nothing reaches the 256 x 8 storage array until a stop arrives after at least one byte.

On a stop the engine visits the eight slots of the page in ascending order, one per clock, and drives the array write port for each slot that was filled. It skips any slot whose address lies in the upper half of the space while the write-protect level is high. A self-timed hold interval of `WR_CYCLES` clocks follows. During the walk and the hold `busy` is high and every input event is ignored. The word pointer stays visible on `word_ptr`, so the read side can continue from the loaded or advanced address.

The controller has five states. IDLE: no address is held. ADDR: an address is loaded and no byte has arrived yet. FILL: one or more bytes are buffered. COMMIT: the slot walk. HOLD: the timed write interval. The transitions are:
- IDLE to ADDR on an address load.
- ADDR to FILL on a data byte.
- ADDR to ADDR on a restart or a new address.
- ADDR to IDLE on a stop.
- FILL to ADDR on a restart or a new address, which discards the buffer.
- FILL to COMMIT on a stop.
- COMMIT to HOLD after the last slot.
- HOLD to IDLE when the timer expires.

When several events arrive in the same cycle, the order of precedence is stop, then restart, then address load, then data.

Top module: `page_commit_engine`

## Requirements
- R1: After reset `busy` and `mem_we` are 0 and `word_ptr` is 0.
- R2: An address load accepted while not busy sets `word_ptr` to `addr_in` in the next cycle.
- R3: Each accepted data byte adds one to bits [2:0] of `word_ptr` modulo 8, so offset 7 is followed by offset 0. Bits [7:3] do not change.
- R4: No array write occurs before a stop. A stop with no buffered byte causes no write and leaves `busy` low.
- R5: After a stop with buffered bytes, exactly one write is issued for each received offset, and none for the other offsets. Each write targets {`word_ptr`[7:3], offset`}` and carries the last byte received for that offset. The writes are issued in ascending offset order during the 8 cycles after the stop.
- R6: `busy` rises in the cycle after such a stop and stays high for exactly 8 + `WR_CYCLES` cycles.
- R7: While `busy` is high, address loads, data strobes, stops and restarts have no effect: `word_ptr` holds its value and no extra write is issued.
- R8: While `wp_level` is 1, no write goes to an address with bit 7 set. Writes to addresses below 80h still go through. While `wp_level` is 0, every address is written.
- R9: A restart with no byte buffered leaves `word_ptr` unchanged and writes nothing. A restart after bytes discards them, so the following stop writes nothing.
- R10: A data strobe in IDLE is ignored: `word_ptr` does not change and no write follows.
- R11: `mem_we` is only ever 1 while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | One-cycle pulse: load word address |
| addr_in | input | ADDR_W | Word address to load |
| data_strobe | input | 1 | One-cycle pulse: one data byte received |
| data_in | input | DATA_W | Data byte |
| stop_commit | input | 1 | One-cycle pulse: stop seen on the bus |
| bus_restart | input | 1 | One-cycle pulse: repeated start seen on the bus |
| wp_level | input | 1 | Write-protect level for the upper half |
| busy | output | 1 | Commit walk or timed write in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| word_ptr | output | ADDR_W | Current word pointer |

## Verification
A stale buffer slot shows up at the array port as a write that should not happen, or as wrong data, within 8 cycles of the stop. A wrong page or wrap in the pointer shows on `word_ptr` in the cycle after the offending strobe, and again on `mem_addr` during the walk. A faulty timer changes the length of the `busy` window, which is counted cycle by cycle. A state that accepts input while busy shows as a moved `word_ptr` or as an extra write compared against the scoreboard queue.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_FILL,
        ST_COMMIT,
        ST_HOLD
    } pcw_state_t;
endpackage

// File: rtl/pcw_addr_ptr.sv
module pcw_addr_ptr #(
    parameter int ADDR_W = 8,
    parameter int OFF_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              bump,
    output logic [ADDR_W-1:0] ptr
);
    // Only the in-page offset advances; the row bits stay put.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (bump) begin
            ptr[OFF_W-1:0] <= ptr[OFF_W-1:0] + 1'b1;
        end
    end
endmodule

// File: rtl/pcw_page_buffer.sv
module pcw_page_buffer #(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 8,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [DATA_W-1:0]     slot_data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] slot_vld;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_data[g] <= '0;
                slot_vld[g]  <= 1'b0;
            end else if (clear) begin
                slot_vld[g]  <= 1'b0;
            end else if (wr_en && (wr_off == OFF_W'(g))) begin
                slot_data[g] <= wr_data;
                slot_vld[g]  <= 1'b1;
            end
        end
    end

    assign rd_data  = slot_data[rd_off];
    assign rd_valid = slot_vld[rd_off];
endmodule

// File: rtl/pcw_write_timer.sv
module pcw_write_timer #(
    parameter int CYCLES = 16,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Asserted in the final cycle of the hold window.
    assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine
    import pcw_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 8,
    parameter int WR_CYCLES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              data_strobe,
    input  logic [DATA_W-1:0] data_in,
    input  logic              stop_commit,
    input  logic              bus_restart,
    input  logic              wp_level,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] word_ptr
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam logic [OFF_W-1:0] LAST_SLOT = OFF_W'(PAGE_BYTES - 1);

    pcw_state_t       state_q, state_d;
    logic [OFF_W-1:0] slot_q;
    logic             last_slot;
    logic             ptr_load, ptr_bump, buf_wr, buf_clear;
    logic             tmr_start, tmr_done, walk_slot;
    logic             slot_valid, slot_locked;

    pcw_addr_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(addr_in),
        .bump(ptr_bump), .ptr(word_ptr)
    );

    pcw_page_buffer #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n), .clear(buf_clear), .wr_en(buf_wr),
        .wr_off(word_ptr[OFF_W-1:0]), .wr_data(data_in),
        .rd_off(slot_q), .rd_data(mem_wdata), .rd_valid(slot_valid)
    );

    pcw_write_timer #(.CYCLES(WR_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .done(tmr_done)
    );

    assign last_slot = (slot_q == LAST_SLOT);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Slot walker for the commit phase
    always_ff @(posedge clk) begin
        if (!rst_n)                   slot_q <= '0;
        else if (state_q == ST_COMMIT) slot_q <= slot_q + 1'b1;
        else                          slot_q <= '0;
    end

    // Next-state logic; event precedence: stop, restart, address, data
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (addr_load) state_d = ST_ADDR;
            end
            ST_ADDR: begin
                if (stop_commit)                    state_d = ST_IDLE;
                else if (bus_restart || addr_load)  state_d = ST_ADDR;
                else if (data_strobe)               state_d = ST_FILL;
            end
            ST_FILL: begin
                if (stop_commit)                    state_d = ST_COMMIT;
                else if (bus_restart || addr_load)  state_d = ST_ADDR;
            end
            ST_COMMIT: begin
                if (last_slot) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output and control decode
    always_comb begin
        ptr_load  = 1'b0;
        ptr_bump  = 1'b0;
        buf_wr    = 1'b0;
        buf_clear = 1'b0;
        tmr_start = 1'b0;
        walk_slot = 1'b0;
        busy      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ptr_load = addr_load;
            end
            ST_ADDR, ST_FILL: begin
                if (stop_commit) begin
                    ptr_load = 1'b0;
                end else if (bus_restart) begin
                    buf_clear = 1'b1;
                end else if (addr_load) begin
                    ptr_load  = 1'b1;
                    buf_clear = 1'b1;
                end else if (data_strobe) begin
                    ptr_bump = 1'b1;
                    buf_wr   = 1'b1;
                end
            end
            ST_COMMIT: begin
                busy      = 1'b1;
                walk_slot = 1'b1;
                if (last_slot) begin
                    tmr_start = 1'b1;
                    buf_clear = 1'b1;
                end
            end
            ST_HOLD: begin
                busy = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    assign mem_addr    = {word_ptr[ADDR_W-1:OFF_W], slot_q};
    assign slot_locked = wp_level && mem_addr[ADDR_W-1];
    assign mem_we      = walk_slot && slot_valid && !slot_locked;
endmodule

// File: rtl/pcw_checker.sv
module pcw_checker #(
    parameter int ADDR_W = 8,
    parameter int OFF_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] word_ptr,
    input logic              wp_level,
    input logic              stop_commit
);
    AST_WE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);  // R11
    AST_PTR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(word_ptr));  // R7
    AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[ADDR_W-1:OFF_W] == word_ptr[ADDR_W-1:OFF_W]));  // R5
    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr[OFF_W-1:0] > $past(mem_addr[OFF_W-1:0])));  // R5
    AST_WP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && wp_level) |-> !mem_addr[ADDR_W-1]);  // R8
    AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_commit));  // R6
endmodule

bind page_commit_engine pcw_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_pcw_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
    .word_ptr(word_ptr), .wp_level(wp_level), .stop_commit(stop_commit)
);

// File: tb/page_commit_engine_bench.sv
module page_commit_engine_bench;
    localparam int PB = 8;
    localparam int WR = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_load = 1'b0, data_strobe = 1'b0, stop_commit = 1'b0;
    logic       bus_restart = 1'b0, wp_level = 1'b0;
    logic [7:0] addr_in = '0, data_in = '0;
    logic       busy, mem_we;
    logic [7:0] mem_addr, mem_wdata, word_ptr;

    always #2 clk = ~clk;

    page_commit_engine #(.WR_CYCLES(WR)) u_page_commit_engine (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .data_strobe(data_strobe), .data_in(data_in), .stop_commit(stop_commit),
        .bus_restart(bus_restart), .wp_level(wp_level), .busy(busy),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .word_ptr(word_ptr)
    );

    int          checks = 0;
    int          errors = 0;
    logic [15:0] exp_q[$];
    logic [7:0]  exp_ptr = '0;
    logic [7:0]  bm [PB];
    logic [PB-1:0] bv = '0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Monitor: pop and compare each array write
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected write", {mem_addr, mem_wdata}, 0);
            end else begin
                logic [15:0] item;
                item = exp_q.pop_front();
                check({mem_addr, mem_wdata} == item, "R5 write addr/data",
                      {mem_addr, mem_wdata}, item);
            end
        end
    end

    task automatic load(input logic [7:0] a);
        @(negedge clk); addr_load = 1'b1; addr_in = a;
        @(negedge clk); addr_load = 1'b0;
        exp_ptr = a;
        bv = '0;
        check(word_ptr == a, "R2 address load", word_ptr, a);
    endtask

    task automatic send(input logic [7:0] d);
        @(negedge clk); data_strobe = 1'b1; data_in = d;
        @(negedge clk); data_strobe = 1'b0;
        bm[exp_ptr[2:0]] = d;
        bv[exp_ptr[2:0]] = 1'b1;
        exp_ptr = {exp_ptr[7:3], exp_ptr[2:0] + 3'd1};
        check(word_ptr == exp_ptr, "R3 pointer step", word_ptr, exp_ptr);
    endtask

    task automatic restart();
        @(negedge clk); bus_restart = 1'b1;
        @(negedge clk); bus_restart = 1'b0;
        bv = '0;
        check(word_ptr == exp_ptr, "R9 pointer after restart", word_ptr, exp_ptr);
    endtask

    // Driver: push expected writes, pulse stop, watch the busy window
    task automatic commit(input bit poke);
        int n;
        bit expect_busy;
        expect_busy = (bv != '0);
        if (expect_busy) begin
            for (int o = 0; o < PB; o++) begin
                logic [7:0] a;
                a = {exp_ptr[7:3], 3'(o)};
                if (bv[o] && !(wp_level && a[7])) exp_q.push_back({a, bm[o]});
            end
        end
        @(negedge clk); stop_commit = 1'b1;
        @(negedge clk); stop_commit = 1'b0;
        check(busy == expect_busy, "R4/R6 busy after stop", busy, expect_busy);
        n = 0;
        while (busy) begin
            n++;
            if (poke && n == 3) begin
                addr_load = 1'b1; addr_in = 8'hAA; data_strobe = 1'b1; data_in = 8'h5A;
                stop_commit = 1'b1; bus_restart = 1'b1;
            end
            if (poke && n == 4) begin
                addr_load = 1'b0; data_strobe = 1'b0; stop_commit = 1'b0; bus_restart = 1'b0;
            end
            @(negedge clk);
        end
        if (expect_busy) check(n == PB + WR, "R6 busy length", n, PB + WR);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R5 all expected writes seen", exp_q.size(), 0);
        check(word_ptr == exp_ptr, "R7 pointer held through commit", word_ptr, exp_ptr);
        check(busy == 1'b0, "R4 idle after commit", busy, 0);
        bv = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy reset", busy, 0);
        check(mem_we == 1'b0, "R1 mem_we reset", mem_we, 0);
        check(word_ptr == 8'h00, "R1 pointer reset", word_ptr, 0);

        // R10: strobe with no address loaded
        @(negedge clk); data_strobe = 1'b1; data_in = 8'h77;
        @(negedge clk); data_strobe = 1'b0;
        check(word_ptr == 8'h00, "R10 strobe in idle ignored", word_ptr, 0);
        commit(1'b0);

        // R4: stop with address but no data
        load(8'h33);
        commit(1'b0);

        // R5/R6: short transfer
        load(8'h10);
        send(8'hA1); send(8'hA2); send(8'hA3);
        commit(1'b0);

        // R3: wrap inside the row, overwrite offsets 5 and 6
        load(8'h25);
        for (int i = 0; i < 10; i++) send(8'hC0 + 8'(i));
        check(word_ptr == 8'h27, "R3 wrap stays in row", word_ptr, 8'h27);
        commit(1'b0);

        // R5: single byte leaves the rest of the page alone
        load(8'h32);
        send(8'h5E);
        commit(1'b0);

        // R8: protected upper half, lower half still writable
        wp_level = 1'b1;
        load(8'h90); send(8'h11); send(8'h22);
        commit(1'b0);
        load(8'h40); send(8'h33); send(8'h44);
        commit(1'b0);
        wp_level = 1'b0;
        load(8'hF8); send(8'h55);
        commit(1'b0);

        // R9: restart before and after data
        load(8'h55);
        restart();
        commit(1'b0);
        load(8'h60); send(8'h99);
        restart();
        commit(1'b0);

        // R7: events during busy are ignored
        load(8'h08); send(8'h66);
        commit(1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule